// File: doc/BRIEF.md
# CPU Single-Step Debug Controller

This block holds or releases an 8-bit two-phase-clock microprocessor through its ready input, so that an operator can move the CPU forward one bus cycle or one instruction per button press. The CPU clock is never gated. A fast system clock samples the phase-2 clock, the opcode-fetch marker and the read/write line through synchronisers. Every decision is taken on the detected falling edge of phase 2, so the ready line only moves during the low half of phase 2.

Two raw pushbuttons feed the block: step and run/halt. Each one passes through its own debounce filter, which emits a single-clock pulse for every clean press. In run mode the ready line stays high and step presses are ignored. In halt mode a step press opens the CPU for one bus cycle, or for one instruction when the instruction mode select is high. A write cycle cannot be frozen, so it stretches a single-cycle step instead of ending it. It also locks the step button until the operator re-arms it with one extra press.

Sync and read/write are sampled at each phase-2 falling edge and describe the bus cycle that begins at that edge.

Top module: `cpu_step_ctrl`

## Requirements
- R1: After reset, readyOut is low and haltedOut is high.
- R2: A button level must hold for DB_LEN consecutive system clocks before it is accepted. A bouncy press gives exactly one step, and a blip shorter than DB_LEN clocks gives none.
- R3: In cycle mode (instrMode low), one accepted step press raises readyOut for exactly one phase-2 cycle. It is then low again.
- R4: readyOut changes only while phi2 is low.
- R5: In instruction mode (instrMode high), readyOut stays high from the starting edge until the first later phase-2 falling edge at which syncIn is high. It drops at that edge.
- R6: In cycle mode, a write cycle (rwIn low) starting at the edge that would end the step keeps readyOut high. Up to WR_LIM (default 3) such consecutive write cycles are absorbed. The step ends at the first read, or at the first edge after the limit is reached.
- R7: A write cycle seen during a step locks stepping. The next step press only re-arms the lock and gives no ready pulse, and the press after that steps normally.
- R8: A run/halt press toggles run mode, and haltedOut goes low at once. While running, readyOut is high from the next phase-2 falling edge onward and never drops. Step presses made while running have no effect, either then or after halt is resumed.
- R9: A run/halt press in run mode sets haltedOut high, and readyOut falls at the next phase-2 falling edge.
- R10: A step press accepted at any position within the phase-2 period gives exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than phi2 |
| rstN | input | 1 | Active-low asynchronous reset |
| phi2 | input | 1 | CPU phase-2 clock |
| syncIn | input | 1 | Opcode-fetch marker from the CPU |
| rwIn | input | 1 | CPU read/write line, high = read |
| instrMode | input | 1 | Step granularity: 0 = bus cycle, 1 = instruction |
| stepBtn | input | 1 | Raw step pushbutton, high = pressed |
| runBtn | input | 1 | Raw run/halt pushbutton, high = pressed |
| readyOut | output | 1 | Ready line to the CPU, high = run |
| haltedOut | output | 1 | High while in halt/step mode |

## Verification
The step press pulse from the debouncer and the detected phase-2 falling edge can land on the same system clock. The press can also arrive just before or just after the edge that starts a step. The bench provokes this by delaying the press by every clock offset within one phase-2 period, from 0 to 15. Each time, it counts phase-2 cycles with readyOut high, and expects exactly one: no step lost to the coincidence and none doubled by it.

// File: rtl/step_dbg_pkg.sv
package step_dbg_pkg;
  localparam int NBTN = 2;
  localparam int BTN_STEP = 0;
  localparam int BTN_RUN = 1;

  // strobes from the control FSM to the datapath flops
  typedef struct packed {
    logic readyOn;
    logic readyOff;
    logic writeSet;
    logic writeClr;
  } stepStrobeT;

  // synchronised events and state from datapath to control
  typedef struct packed {
    logic phiFall;
    logic syncHi;
    logic isWrite;
    logic stepPress;
    logic runPress;
    logic writeOk;
  } stepEventT;
endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int DB_LEN = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic pressOut
);
  localparam int CW = $clog2(DB_LEN + 1);

  logic [1:0]    syncQ;
  logic          stableQ;
  logic [CW-1:0] cntQ;
  logic          pulseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      stableQ <= 1'b0;
      cntQ    <= '0;
      pulseQ  <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] != stableQ) begin
        if (cntQ == CW'(DB_LEN - 1)) begin
          stableQ <= syncQ[1];
          cntQ    <= '0;
          pulseQ  <= syncQ[1];
        end else begin
          cntQ   <= cntQ + 1'b1;
          pulseQ <= 1'b0;
        end
      end else begin
        cntQ   <= '0;
        pulseQ <= 1'b0;
      end
    end
  end

  assign pressOut = pulseQ;

  // R2: a press yields a single-clock pulse
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |=> !pulseQ);
endmodule

// File: rtl/step_dbg_datapath.sv
module step_dbg_datapath
  import step_dbg_pkg::*;
#(
  parameter int DB_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       phi2,
  input  logic       syncIn,
  input  logic       rwIn,
  input  logic       stepBtn,
  input  logic       runBtn,
  input  stepStrobeT st,
  output stepEventT  ev,
  output logic       readyOut
);
  logic [2:0]      busS1, busS2;
  logic            phiPrev;
  logic [NBTN-1:0] rawBtn, pressPulse;
  logic            readyQ, writeOkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busS1   <= 3'b001;
      busS2   <= 3'b001;
      phiPrev <= 1'b0;
    end else begin
      busS1   <= {phi2, syncIn, rwIn};
      busS2   <= busS1;
      phiPrev <= busS2[2];
    end
  end

  assign rawBtn[BTN_STEP] = stepBtn;
  assign rawBtn[BTN_RUN]  = runBtn;

  for (genvar i = 0; i < NBTN; i++) begin : g_btn
    btn_debounce #(.DB_LEN(DB_LEN)) u_db (
      .clk(clk), .rstN(rstN), .rawIn(rawBtn[i]), .pressOut(pressPulse[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ   <= 1'b0;
      writeOkQ <= 1'b1;
    end else begin
      if (st.readyOn)       readyQ <= 1'b1;
      else if (st.readyOff) readyQ <= 1'b0;
      if (st.writeClr)      writeOkQ <= 1'b0;
      else if (st.writeSet) writeOkQ <= 1'b1;
    end
  end

  always_comb begin
    ev.phiFall   = phiPrev & ~busS2[2];
    ev.syncHi    = busS2[1];
    ev.isWrite   = ~busS2[0];
    ev.stepPress = pressPulse[BTN_STEP];
    ev.runPress  = pressPulse[BTN_RUN];
    ev.writeOk   = writeOkQ;
  end

  assign readyOut = readyQ;

  // R4: ready moves only in the low half of phase 2
  p_ready_moves_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(readyQ) |-> !busS2[2]);
endmodule

// File: rtl/step_dbg_ctrl.sv
module step_dbg_ctrl
  import step_dbg_pkg::*;
#(
  parameter int WR_LIM = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrMode,
  input  stepEventT  ev,
  output stepStrobeT st,
  output logic       haltedOut
);
  localparam int WRW = $clog2(WR_LIM + 1);

  logic           runningQ, steppingQ, pendingQ;
  logic [WRW-1:0] wrRunQ;
  logic           stopNow, canAccept;

  always_comb begin
    st        = '0;
    stopNow   = instrMode ? ev.syncHi : !(ev.isWrite && (wrRunQ < WRW'(WR_LIM)));
    canAccept = ev.stepPress && !runningQ && !steppingQ && !pendingQ;
    if (ev.phiFall) begin
      if (runningQ) begin
        st.readyOn = 1'b1;
      end else if (steppingQ) begin
        st.writeClr = ev.isWrite;
        st.readyOff = stopNow;
      end else if (pendingQ) begin
        st.readyOn = 1'b1;
      end else begin
        st.readyOff = 1'b1;
      end
    end
    if (canAccept && !ev.writeOk) st.writeSet = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runningQ  <= 1'b0;
      steppingQ <= 1'b0;
      pendingQ  <= 1'b0;
      wrRunQ    <= '0;
    end else begin
      if (ev.phiFall) begin
        if (runningQ) begin
          steppingQ <= 1'b0;
          wrRunQ    <= '0;
        end else if (steppingQ) begin
          if (stopNow) begin
            steppingQ <= 1'b0;
            wrRunQ    <= '0;
          end else if (ev.isWrite) begin
            wrRunQ <= wrRunQ + 1'b1;
          end else begin
            wrRunQ <= '0;
          end
        end else if (pendingQ) begin
          steppingQ <= 1'b1;
          pendingQ  <= 1'b0;
        end
      end
      if (ev.runPress) begin
        runningQ <= ~runningQ;
        pendingQ <= 1'b0;
      end else if (canAccept && ev.writeOk) begin
        pendingQ <= 1'b1;
      end
    end
  end

  assign haltedOut = ~runningQ;

  // R3: a cycle-mode step over a read ends at the next falling edge
  p_cycle_step_ends_r3: assert property (@(posedge clk) disable iff (!rstN)
    (steppingQ && ev.phiFall && !runningQ && !instrMode && !ev.isWrite) |=> !steppingQ);
  // R7: a press while locked never queues a step
  p_lock_blocks_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ev.stepPress && !ev.writeOk) |=> !pendingQ);
  // R8: no step request survives in run mode
  p_run_no_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
    runningQ |-> !pendingQ);
endmodule

// File: rtl/cpu_step_ctrl.sv
module cpu_step_ctrl
  import step_dbg_pkg::*;
#(
  parameter int DB_LEN = 16,
  parameter int WR_LIM = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic phi2,
  input  logic syncIn,
  input  logic rwIn,
  input  logic instrMode,
  input  logic stepBtn,
  input  logic runBtn,
  output logic readyOut,
  output logic haltedOut
);
  stepStrobeT st;
  stepEventT  ev;

  step_dbg_datapath #(.DB_LEN(DB_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .phi2(phi2), .syncIn(syncIn), .rwIn(rwIn),
    .stepBtn(stepBtn), .runBtn(runBtn), .st(st), .ev(ev), .readyOut(readyOut)
  );

  step_dbg_ctrl #(.WR_LIM(WR_LIM)) u_ctrl (
    .clk(clk), .rstN(rstN), .instrMode(instrMode), .ev(ev), .st(st),
    .haltedOut(haltedOut)
  );

  // R8: in run mode ready never drops until halt is chosen again
  p_run_keeps_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!haltedOut && readyOut) |=> (readyOut || haltedOut));
endmodule

// File: tb/cpu_step_ctrl_tb.sv
module cpu_step_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PHI_HALF = 8;
  localparam int DBL = 6;

  logic clk = 1'b0, rstN = 1'b0, phi2 = 1'b0;
  logic syncIn = 1'b0, rwIn = 1'b1, instrMode = 1'b0;
  logic stepBtn = 1'b0, runBtn = 1'b0;
  logic readyOut, haltedOut;

  int checks = 0, fails = 0;
  int hiCnt = 0, loCnt = 0, viol = 0;
  logic planSync [0:7];
  logic planRw [0:7];
  int planLen = 0, planIdx = 0;
  bit done = 0;

  cpu_step_ctrl #(.DB_LEN(DBL), .WR_LIM(3)) u_dut (
    .clk(clk), .rstN(rstN), .phi2(phi2), .syncIn(syncIn), .rwIn(rwIn),
    .instrMode(instrMode), .stepBtn(stepBtn), .runBtn(runBtn),
    .readyOut(readyOut), .haltedOut(haltedOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    repeat (PHI_HALF) @(negedge clk);
    phi2 = ~phi2;
  end

  // bus pattern: next cycle's sync/rw set mid-cycle while CPU is released
  initial forever begin
    @(posedge phi2); #1;
    if (readyOut && planIdx < planLen) begin
      syncIn = planSync[planIdx];
      rwIn   = planRw[planIdx];
      planIdx++;
    end
  end

  initial forever begin
    @(posedge phi2); #2;
    if (readyOut) hiCnt++; else loCnt++;
  end

  initial forever begin
    @(readyOut);
    if (phi2) viol++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setBtn(input bit isRun, input logic v);
    if (isRun) runBtn = v; else stepBtn = v;
  endtask

  task automatic press(input bit isRun);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); setBtn(isRun, i[0] ? 1'b0 : 1'b1);
    end
    @(negedge clk); setBtn(isRun, 1'b1);
    repeat (DBL + 8) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); setBtn(isRun, i[0] ? 1'b1 : 1'b0);
    end
    @(negedge clk); setBtn(isRun, 1'b0);
    repeat (DBL + 8) @(negedge clk);
  endtask

  task automatic waitPhi(input int n);
    repeat (n) @(posedge phi2);
    #3;
  endtask

  task automatic clearPlan();
    planLen = 0; planIdx = 0;
    syncIn = 1'b0; rwIn = 1'b1;
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    check("R1 ready after reset", readyOut, 0);
    check("R1 halted after reset", haltedOut, 1);
  endtask

  task automatic tGlitch();
    hiCnt = 0;
    @(negedge clk); stepBtn = 1'b1;
    repeat (2) @(negedge clk); stepBtn = 1'b0;
    waitPhi(5);
    check("R2 short blip gives no step", hiCnt, 0);
  endtask

  task automatic tCycle();
    hiCnt = 0;
    press(0);
    waitPhi(5);
    check("R3 one cycle per bouncy press (R2)", hiCnt, 1);
    check("R3 ready low after step", readyOut, 0);
  endtask

  task automatic tInstr();
    instrMode = 1'b1;
    for (int i = 0; i < 4; i++) begin
      planSync[i] = (i == 3); planRw[i] = 1'b1;
    end
    planIdx = 0; planLen = 4; hiCnt = 0;
    press(0);
    waitPhi(8);
    check("R5 instruction step runs to next fetch", hiCnt, 4);
    check("R5 ready low at fetch", readyOut, 0);
    instrMode = 1'b0;
    clearPlan();
  endtask

  task automatic tWrites(input int nWr, input int expHi);
    for (int i = 0; i < 5; i++) begin
      planSync[i] = 1'b0; planRw[i] = (i >= nWr);
    end
    planIdx = 0; planLen = 4; hiCnt = 0;
    press(0);
    waitPhi(8);
    check("R6 write cycles stretch the step", hiCnt, expHi);
    clearPlan();
    hiCnt = 0;
    press(0);
    waitPhi(4);
    check("R7 locked press only re-arms", hiCnt, 0);
    hiCnt = 0;
    press(0);
    waitPhi(4);
    check("R7 press after re-arm steps", hiCnt, 1);
  endtask

  task automatic tRun();
    press(1);
    check("R8 halted low in run", haltedOut, 0);
    waitPhi(2);
    hiCnt = 0; loCnt = 0;
    press(0);
    waitPhi(4);
    check("R8 ready never drops while running", loCnt, 0);
    check("R8 ready high while running", readyOut, 1);
    press(1);
    check("R9 halted high after halt press", haltedOut, 1);
    waitPhi(2);
    check("R9 ready low after halt", readyOut, 0);
    hiCnt = 0;
    waitPhi(4);
    check("R8 step press in run left no step", hiCnt, 0);
  endtask

  task automatic tSweep();
    for (int off = 0; off < 2 * PHI_HALF; off++) begin
      @(posedge phi2);
      repeat (off) @(negedge clk);
      hiCnt = 0;
      press(0);
      waitPhi(4);
      check($sformatf("R10 one step at offset %0d", off), hiCnt, 1);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tGlitch();
    tCycle();
    tInstr();
    tWrites(3, 4);
    tWrites(4, 4);
    tRun();
    tSweep();
    check("R4 ready changed while phi2 high", viol, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule